// File: doc/BRIEF.md
# Retire-Step Timer Compare with Host Mailbox

This block keeps a software-visible instruction counter that advances by the number of instructions a core retires in each cycle. The increment may be larger than one. A compare register stands beside the counter. When a step carries the counter from below the compare value to at or above it, the block asks the status unit to raise a timer interrupt. The request goes out even when the step jumps over the exact compare value, and even when the counter wraps during that step. Software acknowledges the timer by writing a new compare value. A separate cycle counter advances by the same amount but cannot be written.

The same register port also serves three other functions. The first is a pair of mailbox words for a host: the outbound word is write-once until the host drains it, and a write to the inbound word drives the host interrupt. The second is a level register that raises or lowers the inter-processor interrupt. The third is a send register that emits a strobe carrying a target value. The pending bits themselves live in the status unit. This block only issues one-cycle set and clear requests toward that unit. Writes arrive on a select/data port, and reads are a combinational mux of the stored registers.

Top module: `tmr_mbox_top`

## Requirements
- R1: After reset every readable register reads zero, and all request and strobe outputs are low.
- R2: At each clock edge, the count and cycle registers both grow by `retire_cnt_i` modulo 2^DATA_W. The new value is readable in the following cycle.
- R3: A count write (select 0) loads the written data and discards that cycle's increment. The cycle register still advances. No timer request comes from that cycle.
- R4: For one cycle after a step, `tmr_set_o` is high when two conditions hold. The old count is below the compare value. The old count plus the increment, summed at DATA_W+1 bits, is at or above the compare value. This includes a step that wraps the counter.
- R5: No timer set request follows a step that starts at or above the compare value. None follows a step whose sum stays below the compare value.
- R6: A compare write (select 1) produces a one-cycle `tmr_clr_o` with no `tmr_set_o`, and the compare register then reads back the written value.
- R7: A to-host write (select 3) is stored only while the register reads zero. Otherwise it is ignored. `host_drain_i` clears the register, and it takes priority over a write in the same cycle.
- R8: A from-host write (select 4) stores the data. It then pulses `host_set_o` if the data is nonzero, or `host_clr_o` if the data is zero.
- R9: An IPI level write (select 6) pulses `ipi_set_o` when data bit 0 is 1, or `ipi_clr_o` when it is 0.
- R10: `ipi_deliver_i` pulses `ipi_set_o` only while `run_i` is high. An IPI level write in the same cycle overrides it.
- R11: A send write (select 5) produces a one-cycle `ipi_send_o`, and `ipi_target_o` carries the written data.
- R12: The read selects are as follows: 0 count, 1 compare, 2 cycle, 3 to-host, 4 from-host. Selects 5, 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Core is running; gates delivered IPIs |
| retire_cnt_i | input | INC_W | Instructions retired this cycle |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register write select |
| wr_data_i | input | DATA_W | Register write data |
| rd_sel_i | input | 3 | Register read select |
| rd_data_o | output | DATA_W | Read data (combinational) |
| host_drain_i | input | 1 | Host has consumed the to-host word |
| ipi_deliver_i | input | 1 | Externally delivered IPI |
| tmr_set_o | output | 1 | Request: set timer pending |
| tmr_clr_o | output | 1 | Request: clear timer pending |
| host_set_o | output | 1 | Request: set host pending |
| host_clr_o | output | 1 | Request: clear host pending |
| ipi_set_o | output | 1 | Request: set IPI pending |
| ipi_clr_o | output | 1 | Request: clear IPI pending |
| ipi_send_o | output | 1 | Outgoing IPI strobe |
| ipi_target_o | output | DATA_W | Target carried by the strobe |

## Verification
Each request and strobe output is registered. It is therefore due exactly one edge after the cycle that caused it, and it holds only until the next edge. Register contents follow the same one-edge rule. The read mux adds no delay, so a value written in one cycle reads back in the next. The bench drives inputs and samples outputs just after each rising edge. Every check therefore sees the result of the edge just passed. The bench computes expected pulses from the old count, the increment and the compare value, using 33-bit arithmetic. It sweeps these values across the wrap and compare boundaries.

// File: rtl/tmr_mbox_pkg.sv
`timescale 1ns/1ps
package tmr_mbox_pkg;

   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_COUNT    = 3'd0,
      SEL_COMPARE  = 3'd1,
      SEL_CYCLE    = 3'd2,
      SEL_TOHOST   = 3'd3,
      SEL_FROMHOST = 3'd4,
      SEL_IPI_SEND = 3'd5,
      SEL_IPI_LVL  = 3'd6,
      SEL_NONE     = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic set;
      logic clr;
   } pend_req_t;

endpackage

// File: rtl/tmr_step_counter.sv
`timescale 1ns/1ps
module tmr_step_counter #(
   parameter int W        = 32,
   parameter int INC_W    = 3,
   parameter bit LOADABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc_i,
   input  logic             ld_en_i,
   input  logic [W-1:0]     ld_val_i,
   output logic [W-1:0]     cnt_o
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic [W-1:0] step_val;

   assign step_val = cnt_q + W'(inc_i);

   generate
      if (LOADABLE) begin : g_loadable
         always_comb cnt_d = ld_en_i ? ld_val_i : step_val;

         AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            ld_en_i |=> (cnt_o == $past(ld_val_i))); // R3

         AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_en_i |=> (cnt_o == $past(cnt_o) + W'($past(inc_i)))); // R2
      end else begin : g_free
         logic unused_ld;
         assign unused_ld = ^{ld_en_i, ld_val_i};
         always_comb cnt_d = step_val;

         AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_o == $past(cnt_o) + W'($past(inc_i)))); // R2
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_cross_detect.sv
`timescale 1ns/1ps
module tmr_cross_detect
   import tmr_mbox_pkg::*;
#(
   parameter int W     = 32,
   parameter int INC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     count_i,
   input  logic [INC_W-1:0] inc_i,
   input  logic             cnt_wr_i,
   input  logic             cmp_wr_i,
   input  logic [W-1:0]     cmp_data_i,
   output logic [W-1:0]     cmp_o,
   output pend_req_t        tmr_req_o
);

   localparam int SUM_W = W + 1;

   logic [W-1:0]     cmp_q;
   logic [SUM_W-1:0] wide_sum;
   logic             below_before;
   logic             reached_after;
   logic             crossing;
   pend_req_t        req_q;

   assign wide_sum      = {1'b0, count_i} + SUM_W'(inc_i);
   assign below_before  = (count_i < cmp_q);
   assign reached_after = (wide_sum >= {1'b0, cmp_q});
   assign crossing      = below_before && reached_after && !cnt_wr_i && !cmp_wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         req_q <= '0;
      end else begin
         req_q.set <= crossing;
         req_q.clr <= cmp_wr_i;
         if (cmp_wr_i) cmp_q <= cmp_data_i;
      end
   end

   assign cmp_o     = cmp_q;
   assign tmr_req_o = req_q;

   AST_TMR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tmr_req_o.set && tmr_req_o.clr)); // R6

   AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr_i |=> (tmr_req_o.clr && cmp_o == $past(cmp_data_i))); // R6

   AST_NO_SET_PAST: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i >= cmp_o) |=> !tmr_req_o.set); // R5

   AST_CNT_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_i |=> !tmr_req_o.set); // R3

endmodule

// File: rtl/tmr_host_mbox.sv
`timescale 1ns/1ps
module tmr_host_mbox
   import tmr_mbox_pkg::*;
#(
   parameter int W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          wr_tohost_i,
   input  logic          wr_fromhost_i,
   input  logic          wr_send_i,
   input  logic          wr_lvl_i,
   input  logic [W-1:0]  wr_data_i,
   input  logic          host_drain_i,
   input  logic          ipi_deliver_i,
   output logic [W-1:0]  tohost_o,
   output logic [W-1:0]  fromhost_o,
   output pend_req_t     host_req_o,
   output pend_req_t     ipi_req_o,
   output logic          send_o,
   output logic [W-1:0]  target_o
);

   logic [W-1:0] tohost_q;
   logic [W-1:0] fromhost_q;
   logic [W-1:0] target_q;
   logic         send_q;
   logic         tohost_empty;
   logic         data_nz;
   pend_req_t    host_q;
   pend_req_t    ipi_q;

   assign tohost_empty = (tohost_q == '0);
   assign data_nz      = (wr_data_i != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tohost_q <= '0;
      end else if (host_drain_i) begin
         tohost_q <= '0;
      end else if (wr_tohost_i && tohost_empty) begin
         tohost_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fromhost_q <= '0;
         host_q     <= '0;
      end else begin
         host_q.set <= wr_fromhost_i && data_nz;
         host_q.clr <= wr_fromhost_i && !data_nz;
         if (wr_fromhost_i) fromhost_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ipi_q <= '0;
      end else if (wr_lvl_i) begin
         ipi_q.set <= wr_data_i[0];
         ipi_q.clr <= !wr_data_i[0];
      end else begin
         ipi_q.set <= ipi_deliver_i && run_i;
         ipi_q.clr <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         send_q   <= 1'b0;
         target_q <= '0;
      end else begin
         send_q <= wr_send_i;
         if (wr_send_i) target_q <= wr_data_i;
      end
   end

   assign tohost_o   = tohost_q;
   assign fromhost_o = fromhost_q;
   assign host_req_o = host_q;
   assign ipi_req_o  = ipi_q;
   assign send_o     = send_q;
   assign target_o   = target_q;

   AST_TOHOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tohost_o != '0 && !host_drain_i) |=> $stable(tohost_o)); // R7

   AST_TOHOST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      host_drain_i |=> (tohost_o == '0)); // R7

   AST_HOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_req_o.set && host_req_o.clr)); // R8

   AST_IPI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ipi_req_o.set && ipi_req_o.clr)); // R9

   AST_IPI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_lvl_i) |=> !ipi_req_o.set); // R10

   AST_SEND_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_send_i |=> (send_o && target_o == $past(wr_data_i))); // R11

endmodule

// File: rtl/tmr_mbox_top.sv
`timescale 1ns/1ps
module tmr_mbox_top
   import tmr_mbox_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int INC_W    = 3,
   parameter bit CYCLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [INC_W-1:0]  retire_cnt_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [2:0]        rd_sel_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              host_drain_i,
   input  logic              ipi_deliver_i,
   output logic              tmr_set_o,
   output logic              tmr_clr_o,
   output logic              host_set_o,
   output logic              host_clr_o,
   output logic              ipi_set_o,
   output logic              ipi_clr_o,
   output logic              ipi_send_o,
   output logic [DATA_W-1:0] ipi_target_o
);

   generate
      if (INC_W < 1 || INC_W >= DATA_W) begin : g_bad_inc
         $error("tmr_mbox_top: INC_W must lie in 1..DATA_W-1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("tmr_mbox_top: DATA_W must be at least 2");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("tmr_mbox_top: select width must be 3");
      end
   endgenerate

   reg_sel_e          wsel;
   reg_sel_e          rsel;
   logic              wr_count;
   logic              wr_compare;
   logic              wr_tohost;
   logic              wr_fromhost;
   logic              wr_send;
   logic              wr_lvl;
   logic [DATA_W-1:0] count_q;
   logic [DATA_W-1:0] cycle_q;
   logic [DATA_W-1:0] cmp_q;
   logic [DATA_W-1:0] tohost_q;
   logic [DATA_W-1:0] fromhost_q;
   pend_req_t         tmr_req;
   pend_req_t         host_req;
   pend_req_t         ipi_req;

   assign wsel        = reg_sel_e'(wr_sel_i);
   assign rsel        = reg_sel_e'(rd_sel_i);
   assign wr_count    = wr_en_i && (wsel == SEL_COUNT);
   assign wr_compare  = wr_en_i && (wsel == SEL_COMPARE);
   assign wr_tohost   = wr_en_i && (wsel == SEL_TOHOST);
   assign wr_fromhost = wr_en_i && (wsel == SEL_FROMHOST);
   assign wr_send     = wr_en_i && (wsel == SEL_IPI_SEND);
   assign wr_lvl      = wr_en_i && (wsel == SEL_IPI_LVL);

   tmr_step_counter #(.W(DATA_W), .INC_W(INC_W), .LOADABLE(1'b1)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (retire_cnt_i),
      .ld_en_i  (wr_count),
      .ld_val_i (wr_data_i),
      .cnt_o    (count_q)
   );

   generate
      if (CYCLE_EN) begin : g_cycle
         tmr_step_counter #(.W(DATA_W), .INC_W(INC_W), .LOADABLE(1'b0)) u_cycle (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (retire_cnt_i),
            .ld_en_i  (1'b0),
            .ld_val_i ('0),
            .cnt_o    (cycle_q)
         );
      end else begin : g_no_cycle
         assign cycle_q = '0;
      end
   endgenerate

   tmr_cross_detect #(.W(DATA_W), .INC_W(INC_W)) u_cross (
      .clk        (clk),
      .rst_n      (rst_n),
      .count_i    (count_q),
      .inc_i      (retire_cnt_i),
      .cnt_wr_i   (wr_count),
      .cmp_wr_i   (wr_compare),
      .cmp_data_i (wr_data_i),
      .cmp_o      (cmp_q),
      .tmr_req_o  (tmr_req)
   );

   tmr_host_mbox #(.W(DATA_W)) u_mbox (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_i         (run_i),
      .wr_tohost_i   (wr_tohost),
      .wr_fromhost_i (wr_fromhost),
      .wr_send_i     (wr_send),
      .wr_lvl_i      (wr_lvl),
      .wr_data_i     (wr_data_i),
      .host_drain_i  (host_drain_i),
      .ipi_deliver_i (ipi_deliver_i),
      .tohost_o      (tohost_q),
      .fromhost_o    (fromhost_q),
      .host_req_o    (host_req),
      .ipi_req_o     (ipi_req),
      .send_o        (ipi_send_o),
      .target_o      (ipi_target_o)
   );

   always_comb begin
      case (rsel)
         SEL_COUNT:    rd_data_o = count_q;
         SEL_COMPARE:  rd_data_o = cmp_q;
         SEL_CYCLE:    rd_data_o = cycle_q;
         SEL_TOHOST:   rd_data_o = tohost_q;
         SEL_FROMHOST: rd_data_o = fromhost_q;
         default:      rd_data_o = '0;
      endcase
   end

   assign tmr_set_o  = tmr_req.set;
   assign tmr_clr_o  = tmr_req.clr;
   assign host_set_o = host_req.set;
   assign host_clr_o = host_req.clr;
   assign ipi_set_o  = ipi_req.set;
   assign ipi_clr_o  = ipi_req.clr;

   AST_RD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_i >= 3'd5) |-> (rd_data_o == '0)); // R12

   AST_SEND_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_send |=> !ipi_send_o); // R11

endmodule

// File: tb/test_tmr_mbox_top.sv
`timescale 1ns/1ps
module test_tmr_mbox_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        run_i;
   logic [2:0]  retire_cnt_i;
   logic        wr_en_i;
   logic [2:0]  wr_sel_i;
   logic [31:0] wr_data_i;
   logic [2:0]  rd_sel_i;
   logic [31:0] rd_data_o;
   logic        host_drain_i;
   logic        ipi_deliver_i;
   logic        tmr_set_o, tmr_clr_o, host_set_o, host_clr_o;
   logic        ipi_set_o, ipi_clr_o, ipi_send_o;
   logic [31:0] ipi_target_o;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] m_cnt;
   logic [31:0] m_cyc;

   always #2.5 clk = ~clk;

   tmr_mbox_top i_tmr_mbox_top (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .retire_cnt_i(retire_cnt_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .host_drain_i(host_drain_i),
      .ipi_deliver_i(ipi_deliver_i), .tmr_set_o(tmr_set_o), .tmr_clr_o(tmr_clr_o),
      .host_set_o(host_set_o), .host_clr_o(host_clr_o), .ipi_set_o(ipi_set_o),
      .ipi_clr_o(ipi_clr_o), .ipi_send_o(ipi_send_o), .ipi_target_o(ipi_target_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rdchk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
      rd_sel_i = sel;
      #0.1;
      chk(tag, rd_data_o, exp);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data, input logic [2:0] inc);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data; retire_cnt_i = inc;
      tick();
      wr_en_i = 1'b0; retire_cnt_i = '0;
      m_cyc = m_cyc + 32'(inc);
      if (sel == 3'd0) m_cnt = data;
      else             m_cnt = m_cnt + 32'(inc);
   endtask

   task automatic step(input logic [2:0] inc);
      retire_cnt_i = inc;
      tick();
      retire_cnt_i = '0;
      m_cyc = m_cyc + 32'(inc);
      m_cnt = m_cnt + 32'(inc);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] cmps [4];
      rst_n = 1'b0; run_i = 1'b1; retire_cnt_i = '0; wr_en_i = 1'b0;
      wr_sel_i = '0; wr_data_i = '0; rd_sel_i = '0; host_drain_i = 1'b0;
      ipi_deliver_i = 1'b0;
      m_cnt = '0; m_cyc = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      for (int s = 0; s < 8; s++) rdchk("R1 read", 3'(s), 32'h0);
      chk("R1 pulses", {25'd0, tmr_set_o, tmr_clr_o, host_set_o, host_clr_o,
                        ipi_set_o, ipi_clr_o, ipi_send_o}, 32'h0);

      // R2: count and cycle advance by increments
      for (int i = 0; i < 8; i++) begin
         step(3'(i));
         rdchk("R2 count", 3'd0, m_cnt);
         rdchk("R2 cycle", 3'd2, m_cyc);
      end
      wr(3'd0, 32'hFFFF_FFFD, 3'd0);
      step(3'd7);
      rdchk("R2 count wrap", 3'd0, 32'h0000_0004);

      // R3: software count write beats increment; cycle still advances
      wr(3'd0, 32'h0000_1234, 3'd5);
      rdchk("R3 count", 3'd0, 32'h0000_1234);
      rdchk("R3 cycle", 3'd2, m_cyc);
      wr(3'd1, 32'h0000_1236, 3'd0);
      wr(3'd0, 32'h0000_1230, 3'd7);
      chk("R3 no timer on count write", {31'd0, tmr_set_o}, 32'd0);

      // R4/R5/R6: sweep around compare boundaries, including wrap
      cmps[0] = 32'd5; cmps[1] = 32'h8000_0000; cmps[2] = 32'hFFFF_FFFC; cmps[3] = 32'd0;
      foreach (cmps[c]) begin
         for (int d = 0; d < 10; d++) begin
            for (int inc = 0; inc < 8; inc++) begin
               logic [31:0] old;
               logic [32:0] sum;
               logic        expset;
               old = cmps[c] - 32'd8 + 32'(d);
               sum = {1'b0, old} + 33'(inc);
               expset = (old < cmps[c]) && (sum >= {1'b0, cmps[c]});
               wr(3'd0, old, 3'd0);
               wr(3'd1, cmps[c], 3'd0);
               chk("R6 clr pulse", {30'd0, tmr_clr_o, tmr_set_o}, 32'b10);
               step(3'(inc));
               if (expset) chk("R4 crossing set", {31'd0, tmr_set_o}, 32'd1);
               else        chk("R5 no crossing", {31'd0, tmr_set_o}, 32'd0);
               chk("R6 clr one cycle", {31'd0, tmr_clr_o}, 32'd0);
            end
         end
      end
      rdchk("R2 count after sweep", 3'd0, m_cnt);
      rdchk("R2 cycle after sweep", 3'd2, m_cyc);

      // R6: compare write during a crossing step suppresses set
      wr(3'd0, 32'd10, 3'd0);
      wr(3'd1, 32'd12, 3'd0);
      wr(3'd1, 32'd100, 3'd5);
      chk("R6 clr not set", {30'd0, tmr_clr_o, tmr_set_o}, 32'b10);
      rdchk("R6 compare readback", 3'd1, 32'd100);
      step(3'd0);
      chk("R6 quiet after", {30'd0, tmr_clr_o, tmr_set_o}, 32'b00);

      // R7: to-host write-once until drained
      wr(3'd3, 32'hA5A5_0001, 3'd0);
      rdchk("R7 first write", 3'd3, 32'hA5A5_0001);
      wr(3'd3, 32'h0000_0BBB, 3'd0);
      rdchk("R7 ignored write", 3'd3, 32'hA5A5_0001);
      host_drain_i = 1'b1; tick(); host_drain_i = 1'b0;
      rdchk("R7 drained", 3'd3, 32'h0);
      wr(3'd3, 32'h0000_0BBB, 3'd0);
      rdchk("R7 refill", 3'd3, 32'h0000_0BBB);
      host_drain_i = 1'b1;
      wr(3'd3, 32'h0000_0CCC, 3'd0);
      host_drain_i = 1'b0;
      rdchk("R7 drain wins", 3'd3, 32'h0);

      // R8: from-host store and host interrupt
      wr(3'd4, 32'h0000_0042, 3'd0);
      chk("R8 set", {30'd0, host_set_o, host_clr_o}, 32'b10);
      rdchk("R8 stored", 3'd4, 32'h0000_0042);
      wr(3'd4, 32'h0, 3'd0);
      chk("R8 clr", {30'd0, host_set_o, host_clr_o}, 32'b01);
      rdchk("R8 stored zero", 3'd4, 32'h0);
      tick();
      chk("R8 idle", {30'd0, host_set_o, host_clr_o}, 32'b00);

      // R9: IPI level by bit 0
      wr(3'd6, 32'd1, 3'd0);
      chk("R9 bit0=1", {30'd0, ipi_set_o, ipi_clr_o}, 32'b10);
      wr(3'd6, 32'd2, 3'd0);
      chk("R9 bit0=0", {30'd0, ipi_set_o, ipi_clr_o}, 32'b01);
      wr(3'd6, 32'd3, 3'd0);
      chk("R9 bit0=1 upper", {30'd0, ipi_set_o, ipi_clr_o}, 32'b10);

      // R10: delivered IPI gated by run
      run_i = 1'b1; ipi_deliver_i = 1'b1; tick(); ipi_deliver_i = 1'b0;
      chk("R10 running", {30'd0, ipi_set_o, ipi_clr_o}, 32'b10);
      run_i = 1'b0; ipi_deliver_i = 1'b1; tick(); ipi_deliver_i = 1'b0;
      chk("R10 halted", {30'd0, ipi_set_o, ipi_clr_o}, 32'b00);
      run_i = 1'b1; ipi_deliver_i = 1'b1;
      wr(3'd6, 32'd0, 3'd0);
      ipi_deliver_i = 1'b0;
      chk("R10 write overrides", {30'd0, ipi_set_o, ipi_clr_o}, 32'b01);

      // R11: send strobe
      wr(3'd5, 32'h0000_0007, 3'd0);
      chk("R11 strobe", {31'd0, ipi_send_o}, 32'd1);
      chk("R11 target", ipi_target_o, 32'h0000_0007);
      tick();
      chk("R11 one cycle", {31'd0, ipi_send_o}, 32'd0);

      // R12: spare and write-only selects read zero
      rdchk("R12 sel5", 3'd5, 32'h0);
      rdchk("R12 sel6", 3'd6, 32'h0);
      rdchk("R12 sel7", 3'd7, 32'h0);
      rdchk("R12 sel0", 3'd0, m_cnt);

      summary();
      $finish;
   end

endmodule